// File: doc/BRIEF.md
# Serial Configuration Port with Register Read-Back

This block is the control port of a scanner analog front end. A host drives three wires, a shift clock, a data line and a commit strobe. Each frame is 14 bits: a 6-bit address followed by an 8-bit data byte, both sent most significant bit first. The port keeps the setup, offset and gain registers and presents them as parallel outputs to the rest of the chip. The serial inputs are brought into the system clock domain through a short synchronizer, and all edges are detected there.

When address bit 4 of a frame is set, the frame asks for a read instead of a write. Its data byte is ignored. The register found at the same address with bit 4 cleared is shifted out, most significant bit first, on bit 3 of the pixel output bus, which the port borrows for the length of the read. The host may shift in its next frame while the read-back word is still being sent. Two write-only command addresses issue fixed-length internal reset pulses. One restores every register to its default. The other restarts the colour sequence counter that lives outside this block.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame of exactly 14 rising shift-clock edges, address bits [13:8] and data bits [7:0] MSB first, is written to the addressed register on the next rising edge of the commit strobe, provided address bit 4 is 0. Registers do not change at any other time, except on a software reset.
- R2: A commit strobe that arrives after any bit count other than 14 is discarded. Every rising edge of the commit strobe clears the bit count.
- R3: After reset the registers hold these values: cfg1=0x0F, cfg2=0x23, cfg3=0x1F, cfg4=0x05, cfg5=0x00, cfg6=0x00. The three offsets (0x20, 0x21, 0x22 for red, green, blue) hold 0x80. The three gains (0x28, 0x29, 0x2A) hold 0x5C. The setup addresses are 0x01, 0x02, 0x03, 0x06, 0x08 and 0x09.
- R4: A write to 0x23 loads its byte into all three offset registers. A read of 0x23 returns the red offset.
- R5: A write to 0x2B loads its byte into all three gain registers. A read of 0x2B returns 0x00.
- R6: A frame with address bit 4 set changes no register and fires no reset command. It starts a read of the register at the same address with bit 4 cleared. The first bit shown is bit 7, and the next bit appears on each following shift-clock falling edge.
- R7: od[3] carries the read-back bit from the read commit until the 8th shift-clock falling edge after it. At all other times od[3] equals pix_in[3]. od[2:0] always equals pix_in[2:0].
- R8: A write to 0x04, with any data, raises soft_rst for PULSE_CYCLES clock cycles and returns every register to its R3 value.
- R9: A write to 0x05 raises acyc_rst for PULSE_CYCLES clock cycles and leaves all registers unchanged.
- R10: Address 0x07 reads 0x41 (REV_ID), and writes to it are ignored. Writes to undefined addresses are ignored, and reads of undefined addresses return 0x00.
- R11: A new frame may be shifted in while a read-back is in progress. Committing it after the read-back completes takes effect normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| sen | input | 1 | Commit strobe, active high |
| pix_in | input | 4 | Pixel nibble from the datapath |
| od | output | 4 | Output bus; bit 3 shared with serial read-back |
| soft_rst | output | 1 | Software reset pulse |
| acyc_rst | output | 1 | Colour-sequence restart pulse |
| cfg1 | output | 8 | Setup register at 0x01 |
| cfg2 | output | 8 | Setup register at 0x02 |
| cfg3 | output | 8 | Setup register at 0x03 |
| cfg4 | output | 8 | Setup register at 0x06 |
| cfg5 | output | 8 | Setup register at 0x08 |
| cfg6 | output | 8 | Setup register at 0x09 |
| offset_r | output | 8 | Red offset |
| offset_g | output | 8 | Green offset |
| offset_b | output | 8 | Blue offset |
| gain_r | output | 8 | Red gain |
| gain_g | output | 8 | Green gain |
| gain_b | output | 8 | Blue gain |

## Verification
The bench builds the port with SYNC_STAGES=2 and PULSE_CYCLES=3. The non-default pulse length shows that both command pulses follow the parameter and are not fixed at two cycles. Two synchronizer stages make edge detection lag each serial transition by about three clocks, so the bench holds every serial level for four clocks. This makes it possible to check the exact bit order of a read, the release of the shared pin after the eighth falling edge, and a new frame shifted in during a read. Frames of 13 and 15 bits are included, so that counts just short of and just past a full frame are both covered.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_CYCLES = 2,
  parameter logic [7:0] REV_ID = 8'h41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       sdi,
  input  logic       sen,
  input  logic [3:0] pix_in,
  output logic [3:0] od,
  output logic       soft_rst,
  output logic       acyc_rst,
  output logic [7:0] cfg1,
  output logic [7:0] cfg2,
  output logic [7:0] cfg3,
  output logic [7:0] cfg4,
  output logic [7:0] cfg5,
  output logic [7:0] cfg6,
  output logic [7:0] offset_r,
  output logic [7:0] offset_g,
  output logic [7:0] offset_b,
  output logic [7:0] gain_r,
  output logic [7:0] gain_g,
  output logic [7:0] gain_b
);
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int FW = AW + DW;
  localparam int CW = $clog2(FW + 2);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam int IW = $clog2(DW);
  localparam int RDBIT = 4;

  localparam logic [AW-1:0] A_CFG1 = 6'h01, A_CFG2 = 6'h02, A_CFG3 = 6'h03;
  localparam logic [AW-1:0] A_SRST = 6'h04, A_ACYC = 6'h05, A_CFG4 = 6'h06;
  localparam logic [AW-1:0] A_REV = 6'h07, A_CFG5 = 6'h08, A_CFG6 = 6'h09;
  localparam logic [AW-1:0] A_OFFR = 6'h20, A_OFFG = 6'h21, A_OFFB = 6'h22, A_OFFALL = 6'h23;
  localparam logic [AW-1:0] A_GNR = 6'h28, A_GNG = 6'h29, A_GNB = 6'h2A, A_GNALL = 6'h2B;

  localparam logic [DW-1:0] D_CFG1 = 8'h0F, D_CFG2 = 8'h23, D_CFG3 = 8'h1F;
  localparam logic [DW-1:0] D_CFG4 = 8'h05, D_CFG5 = 8'h00, D_CFG6 = 8'h00;
  localparam logic [DW-1:0] D_OFF = 8'h80, D_GN = 8'h5C;

  logic [SYNC_STAGES-1:0] sck_sy, sdi_sy, sen_sy;
  logic sck_d, sen_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      sdi_sy <= '0;
      sen_sy <= '0;
      sck_d  <= 1'b0;
      sen_d  <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck};
      sdi_sy <= {sdi_sy[SYNC_STAGES-2:0], sdi};
      sen_sy <= {sen_sy[SYNC_STAGES-2:0], sen};
      sck_d  <= sck_sy[SYNC_STAGES-1];
      sen_d  <= sen_sy[SYNC_STAGES-1];
    end
  end

  wire sck_s    = sck_sy[SYNC_STAGES-1];
  wire sdi_s    = sdi_sy[SYNC_STAGES-1];
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;
  wire sen_rise = sen_sy[SYNC_STAGES-1] & ~sen_d;

  logic [FW-1:0] shreg;
  logic [CW-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (sen_rise) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[FW-2:0], sdi_s};
      if (bit_cnt != CW'(FW + 1)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  wire [AW-1:0] wr_addr  = shreg[FW-1:DW];
  wire [DW-1:0] wr_data  = shreg[DW-1:0];
  wire          commit   = sen_rise && (bit_cnt == CW'(FW));
  wire          wr_en    = commit && !wr_addr[RDBIT];
  wire          rd_start = commit && wr_addr[RDBIT];

  logic [PW-1:0] srst_cnt, acyc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_cnt <= '0;
      acyc_cnt <= '0;
    end else begin
      if (wr_en && wr_addr == A_SRST) srst_cnt <= PW'(PULSE_CYCLES);
      else if (srst_cnt != '0)        srst_cnt <= srst_cnt - 1'b1;
      if (wr_en && wr_addr == A_ACYC) acyc_cnt <= PW'(PULSE_CYCLES);
      else if (acyc_cnt != '0)        acyc_cnt <= acyc_cnt - 1'b1;
    end
  end

  assign soft_rst = (srst_cnt != '0);
  assign acyc_rst = (acyc_cnt != '0);

  logic [DW-1:0] c1, c2, c3, c4, c5, c6;
  logic [DW-1:0] off_q [3];
  logic [DW-1:0] gn_q [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= D_CFG1; c2 <= D_CFG2; c3 <= D_CFG3;
      c4 <= D_CFG4; c5 <= D_CFG5; c6 <= D_CFG6;
      for (int k = 0; k < 3; k++) begin
        off_q[k] <= D_OFF;
        gn_q[k]  <= D_GN;
      end
    end else if (soft_rst) begin
      c1 <= D_CFG1; c2 <= D_CFG2; c3 <= D_CFG3;
      c4 <= D_CFG4; c5 <= D_CFG5; c6 <= D_CFG6;
      for (int k = 0; k < 3; k++) begin
        off_q[k] <= D_OFF;
        gn_q[k]  <= D_GN;
      end
    end else if (wr_en) begin
      case (wr_addr)
        A_CFG1: c1 <= wr_data;
        A_CFG2: c2 <= wr_data;
        A_CFG3: c3 <= wr_data;
        A_CFG4: c4 <= wr_data;
        A_CFG5: c5 <= wr_data;
        A_CFG6: c6 <= wr_data;
        A_OFFR: off_q[0] <= wr_data;
        A_OFFG: off_q[1] <= wr_data;
        A_OFFB: off_q[2] <= wr_data;
        A_GNR:  gn_q[0] <= wr_data;
        A_GNG:  gn_q[1] <= wr_data;
        A_GNB:  gn_q[2] <= wr_data;
        A_OFFALL: for (int k = 0; k < 3; k++) off_q[k] <= wr_data;
        A_GNALL:  for (int k = 0; k < 3; k++) gn_q[k] <= wr_data;
        default: ;
      endcase
    end
  end

  wire [AW-1:0] rd_addr = {wr_addr[AW-1:RDBIT+1], 1'b0, wr_addr[RDBIT-1:0]};
  logic [DW-1:0] rd_val;

  always_comb begin
    case (rd_addr)
      A_CFG1:   rd_val = c1;
      A_CFG2:   rd_val = c2;
      A_CFG3:   rd_val = c3;
      A_CFG4:   rd_val = c4;
      A_REV:    rd_val = REV_ID;
      A_CFG5:   rd_val = c5;
      A_CFG6:   rd_val = c6;
      A_OFFR:   rd_val = off_q[0];
      A_OFFG:   rd_val = off_q[1];
      A_OFFB:   rd_val = off_q[2];
      A_OFFALL: rd_val = off_q[0];
      A_GNR:    rd_val = gn_q[0];
      A_GNG:    rd_val = gn_q[1];
      A_GNB:    rd_val = gn_q[2];
      default:  rd_val = '0;
    endcase
  end

  logic          rd_act;
  logic [DW-1:0] rd_sh;
  logic [IW-1:0] rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act <= 1'b0;
      rd_sh  <= '0;
      rd_idx <= '0;
    end else if (rd_start) begin
      rd_act <= 1'b1;
      rd_sh  <= rd_val;
      rd_idx <= '0;
    end else if (rd_act && sck_fall) begin
      if (rd_idx == IW'(DW - 1)) begin
        rd_act <= 1'b0;
      end else begin
        rd_sh  <= {rd_sh[DW-2:0], 1'b0};
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  assign od = {rd_act ? rd_sh[DW-1] : pix_in[3], pix_in[2:0]};

  assign cfg1 = c1; assign cfg2 = c2; assign cfg3 = c3;
  assign cfg4 = c4; assign cfg5 = c5; assign cfg6 = c6;
  assign offset_r = off_q[0]; assign offset_g = off_q[1]; assign offset_b = off_q[2];
  assign gain_r = gn_q[0]; assign gain_g = gn_q[1]; assign gain_b = gn_q[2];

  wire [12*DW-1:0] regs_flat = {c1, c2, c3, c4, c5, c6,
                                off_q[0], off_q[1], off_q[2], gn_q[0], gn_q[1], gn_q[2]};

  // R1
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !soft_rst) |=> $stable(regs_flat));

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sen_rise |=> (bit_cnt == '0));

  // R6
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && !sck_fall && !rd_start) |=> $stable(od[3]) || !rd_act);

  // R7
  rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_act) |-> $past(sck_fall));

  // R8
  srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SRST) |=> soft_rst);

  // R9
  acyc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ACYC) |=> acyc_rst);
endmodule

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 3;
  localparam int HOLD = 4;
  localparam logic [5:0] FILL = 6'h2F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, sen = 1'b0;
  logic [3:0] pix_in = 4'h0;
  logic [3:0] od;
  logic soft_rst, acyc_rst;
  logic [7:0] cfg1, cfg2, cfg3, cfg4, cfg5, cfg6;
  logic [7:0] offset_r, offset_g, offset_b, gain_r, gain_g, gain_b;

  int checks = 0;
  int errors = 0;
  int srst_seen = 0;
  int acyc_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (soft_rst) srst_seen <= srst_seen + 1;
    if (acyc_rst) acyc_seen <= acyc_seen + 1;
  end

  serial_cfg_port #(.SYNC_STAGES(2), .PULSE_CYCLES(PULSE), .REV_ID(8'h41)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sen(sen), .pix_in(pix_in),
    .od(od), .soft_rst(soft_rst), .acyc_rst(acyc_rst),
    .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3), .cfg4(cfg4), .cfg5(cfg5), .cfg6(cfg6),
    .offset_r(offset_r), .offset_g(offset_g), .offset_b(offset_b),
    .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b)
  );

  // {write addr, write data, read addr, expected, requirement}
  localparam logic [31:0] VEC [11] = '{
    {6'h01, 8'hA5, 6'h01, 8'hA5, 4'd1},   // R1
    {6'h09, 8'h3C, 6'h09, 8'h3C, 4'd1},   // R1
    {6'h21, 8'h11, 6'h21, 8'h11, 4'd1},   // R1
    {6'h23, 8'h77, 6'h20, 8'h77, 4'd4},   // R4
    {6'h23, 8'h78, 6'h22, 8'h78, 4'd4},   // R4
    {6'h2B, 8'h9A, 6'h29, 8'h9A, 4'd5},   // R5
    {6'h2B, 8'h9B, 6'h2B, 8'h00, 4'd5},   // R5
    {6'h07, 8'hFF, 6'h07, 8'h41, 4'd10},  // R10
    {6'h0D, 8'h55, 6'h0D, 8'h00, 4'd10},  // R10
    {6'h2A, 8'hC3, 6'h2A, 8'hC3, 4'd6},   // R6
    {6'h23, 8'h66, 6'h23, 8'h66, 4'd4}    // R4
  };

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b; waitc(HOLD);
    sck = 1'b1; waitc(HOLD);
    sck = 1'b0; waitc(HOLD);
  endtask

  task automatic send_frame(input logic [13:0] w, input int nbits);
    if (nbits >= 14) begin
      for (int i = 0; i < nbits - 14; i++) send_bit(1'b1);
      for (int i = 13; i >= 0; i--) send_bit(w[i]);
    end else begin
      for (int i = 13; i > 13 - nbits; i--) send_bit(w[i]);
    end
  endtask

  task automatic pulse_sen;
    sen = 1'b1; waitc(HOLD);
    sen = 1'b0; waitc(HOLD + 2);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    send_frame({a, d}, 14);
    pulse_sen();
  endtask

  task automatic xfer(input logic [5:0] ra, input logic [7:0] exp, input logic [13:0] nxt, input string tag);
    logic [7:0] got;
    got = 8'h00;
    send_frame({ra | 6'h10, 8'h00}, 14);
    pulse_sen();
    for (int i = 0; i < 14; i++) begin
      sdi = nxt[13-i];
      waitc(HOLD);
      if (i < 8) got[7-i] = od[3];
      if (i == 3) check({5'd0, od[2:0]}, {5'd0, pix_in[2:0]}, "R7 low pins during read");
      if (i == 8) check({4'd0, od}, {4'd0, pix_in}, "R7 pin released after read");
      sck = 1'b1; waitc(HOLD);
      sck = 1'b0; waitc(HOLD);
    end
    check(got, exp, tag);
    pulse_sen();
  endtask

  task automatic check_defaults(input string tag);
    check(cfg1, 8'h0F, tag); check(cfg2, 8'h23, tag); check(cfg3, 8'h1F, tag);
    check(cfg4, 8'h05, tag); check(cfg5, 8'h00, tag); check(cfg6, 8'h00, tag);
    check(offset_r, 8'h80, tag); check(offset_g, 8'h80, tag); check(offset_b, 8'h80, tag);
    check(gain_r, 8'h5C, tag); check(gain_g, 8'h5C, tag); check(gain_b, 8'h5C, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    pix_in = 4'h9;
    waitc(5);
    rst_n = 1'b1;
    waitc(3);

    // R3 reset values, R7 idle pin
    check_defaults("R3 reset default");
    check({4'd0, od}, {4'd0, pix_in}, "R7 idle pins");
    check({7'd0, soft_rst}, 8'd0, "R8 idle soft_rst");

    for (int v = 0; v < 11; v++) begin
      pix_in = (v % 2 == 0) ? 4'hA : 4'h5;
      wr(VEC[v][31:26], VEC[v][25:18]);
      xfer(VEC[v][17:12], VEC[v][11:4], {FILL, 8'h00}, $sformatf("R%0d vector %0d", VEC[v][3:0], v));
    end
    check(offset_b, 8'h66, "R4 broadcast reaches blue port");
    check(gain_r, 8'h9B, "R5 broadcast reaches red port");

    // R2 short and long frames
    send_frame({6'h02, 8'h99}, 13); pulse_sen();
    check(cfg2, 8'h23, "R2 13-bit frame discarded");
    send_frame({6'h02, 8'h99}, 15); pulse_sen();
    check(cfg2, 8'h23, "R2 15-bit frame discarded");
    wr(6'h02, 8'h99);
    check(cfg2, 8'h99, "R1 write after discarded frames");

    // R6 read of command address neither resets nor modifies
    n0 = srst_seen;
    xfer(6'h04, 8'h00, {FILL, 8'h00}, "R6 read of reset address");
    check(8'(srst_seen - n0), 8'd0, "R6 read fires no soft reset");
    check(cfg1, 8'hA5, "R6 read leaves registers");
    check(offset_g, 8'h66, "R6 read leaves offsets");

    // R11 overlapped frame during read-back
    pix_in = 4'h6;
    xfer(6'h2A, 8'hC3, {6'h03, 8'h4D}, "R11 read during overlap");
    check(cfg3, 8'h4D, "R11 overlapped write committed");

    // R9 colour-sequence restart
    n0 = acyc_seen;
    wr(6'h05, 8'h33);
    check(8'(acyc_seen - n0), 8'(PULSE), "R9 acyc pulse length");
    check(cfg1, 8'hA5, "R9 registers unchanged");
    check(offset_r, 8'h66, "R9 offsets unchanged");

    // R8 software reset
    n0 = srst_seen;
    wr(6'h04, 8'h5A);
    check(8'(srst_seen - n0), 8'(PULSE), "R8 soft reset pulse length");
    check_defaults("R8 defaults after soft reset");
    xfer(6'h07, 8'h41, {FILL, 8'h00}, "R10 revision after soft reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule